// File: doc/BRIEF.md
# Target-Side Byte Sender with Programmable Pause

This block is the send half of a parallel-bus target port. A single command supplies a byte count and a pause index. The engine then takes that many bytes from a valid/ready stream and delivers each one to the initiator with a REQ/ACK interlock. It drives eight data lines and an odd-parity line continuously. When the running byte index reaches the programmed pause index, the engine first waits a fixed number of clock cycles. This lets a peer that needs breathing room between a short header and its payload receive the two as separate bursts.

Every byte follows the same order. The engine loads the byte onto the bus, waits until the initiator has released ACK, raises REQ, waits for ACK to be asserted, and then drops REQ. After the last byte, the engine waits for ACK to be released once more before it reports completion. A transfer also ends early if any ACK wait runs past a cycle limit, or if the bus reset line is asserted. In either case the result count holds the bytes that finished their handshake. ACK and bus reset are asynchronous to the clock and pass through two flops before the engine uses them.

Stream rules: `in_ready` is high only while the engine is waiting for its next byte. A byte is taken on a clock edge where both `in_valid` and `in_ready` are high. The source may hold `in_valid` low for as long as it likes, and a stall is never treated as a timeout. `in_data` only has to be valid while `in_valid` is high.

Top module: `tgt_send_engine`

## Requirements
- R1: During and after reset, `req_out`, `busy`, `done` and `in_ready` are low, `data_out` is 0 and `parity_out` is 1.
- R2: Handshake order for each byte:
  - the byte is accepted from the stream first;
  - REQ rises only once synchronized ACK is low;
  - REQ falls on the 3rd rising clock edge after ACK goes high at the pin.
- R3: `data_out` holds the accepted byte unchanged from its load until the next byte is accepted, which includes the whole time REQ is high.
- R4: `parity_out` equals the inverted XOR of `data_out[7:0]`, so the nine lines together always carry an odd number of ones.
- R5: When `pause_index` is below `byte_count`, at least `PAUSE_CYCLES` clock cycles pass between the previous REQ fall (or the start command, for index 0) and the REQ rise of byte number `pause_index`.
- R6: A `pause_index` of `byte_count` or more inserts no pause. Apart from the paused byte, no inter-byte gap reaches `PAUSE_CYCLES`.
- R7: `busy` is high from the cycle after `start` until completion. After the last byte, `done` pulses for one cycle only once synchronized ACK is low, with `sent_count` equal to `byte_count`.
- R8: Any ACK wait that exceeds `TIMEOUT_CYCLES` ends the transfer. `done` pulses, REQ is low, and `sent_count` holds the number of completed bytes.
- R9: A bus reset seen while busy ends the transfer the same way as R8, with the count of completed bytes.
- R10: While the stream withholds data, REQ stays low, `in_ready` stays high and no timeout occurs, however long the stall lasts.
- R11: A `byte_count` of 0 accepts no byte, raises no REQ, and reports `done` with `sent_count` 0 once ACK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a transfer when idle |
| byte_count | input | CNT_W | Number of bytes to send |
| pause_index | input | CNT_W | Byte index preceded by the pause |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| sent_count | output | CNT_W | Bytes completed, valid from `done` |
| in_valid | input | 1 | Stream byte available |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| ack_in | input | 1 | Initiator ACK, asynchronous |
| bus_rst_in | input | 1 | Bus reset line, asynchronous |
| req_out | output | 1 | Target REQ |
| data_out | output | 8 | Data lines |
| parity_out | output | 1 | Odd parity line |

## Verification
Any change on `ack_in` or `bus_rst_in` reaches the state machine through two synchronizer flops, and a third registered step updates REQ or `done`. The effect is therefore visible after the third rising edge. The bench drives the pins on falling edges and counts falling edges until REQ drops after it raises ACK, expecting exactly three. An accepted stream byte appears on `data_out` one edge after the accepting edge. REQ rises and `done` arrive after waits of unbounded length, so the bench polls for them at falling edges within a cycle limit. It compares the cycle stamps of REQ edges against `PAUSE_CYCLES` and reads the data and parity lines while REQ is high.

// File: rtl/tgt_send_pkg.sv
package tgt_send_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAUSE,
    ST_FETCH,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_LAST
  } tx_state_e;

endpackage

// File: rtl/tgt_sync.sv
module tgt_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/tgt_byte_latch.sv
module tgt_byte_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          par
);

  // Odd parity: the extra line makes the total number of ones odd.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      par  <= 1'b1;
    end else if (load) begin
      dout <= din;
      par  <= ~(^din);
    end
  end

  p_odd_lines_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (^{dout, par}) == 1'b1);

  p_hold_between_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(dout));

endmodule

// File: rtl/tgt_send_fsm.sv
module tgt_send_fsm
  import tgt_send_pkg::*;
#(
  parameter int CNT_W          = 16,
  parameter int PAUSE_CYCLES   = 20000,
  parameter int TIMEOUT_CYCLES = 600000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [CNT_W-1:0] pause_index,
  input  logic             in_valid,
  input  logic             ack_s,
  input  logic             bus_rst_s,
  output logic             in_ready,
  output logic             load,
  output logic             req,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] sent
);

  localparam int TMR_MAX = (PAUSE_CYCLES > TIMEOUT_CYCLES) ? PAUSE_CYCLES : TIMEOUT_CYCLES;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] PAUSE_END = TMR_W'(PAUSE_CYCLES - 1);
  localparam logic [TMR_W-1:0] TO_END    = TMR_W'(TIMEOUT_CYCLES - 1);

  tx_state_e        state;
  logic [CNT_W-1:0] idx, total, pidx;
  logic [TMR_W-1:0] timer;
  logic [CNT_W-1:0] idx_nxt;
  logic             to_hit;

  assign idx_nxt  = idx + CNT_W'(1);
  assign to_hit   = (timer == TO_END);
  assign busy     = (state != ST_IDLE);
  assign in_ready = (state == ST_FETCH) && !bus_rst_s;
  assign load     = in_ready && in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      total <= '0;
      pidx  <= '0;
      timer <= '0;
      req   <= 1'b0;
      done  <= 1'b0;
      sent  <= '0;
    end else begin
      done <= 1'b0;
      if (state != ST_IDLE && bus_rst_s) begin
        req   <= 1'b0;
        done  <= 1'b1;
        sent  <= idx;
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (start) begin
              total <= byte_count;
              pidx  <= pause_index;
              idx   <= '0;
              timer <= '0;
              if (byte_count == '0)       state <= ST_LAST;
              else if (pause_index == '0) state <= ST_PAUSE;
              else                        state <= ST_FETCH;
            end
          end
          ST_PAUSE: begin
            if (timer == PAUSE_END) begin
              timer <= '0;
              state <= ST_FETCH;
            end else begin
              timer <= timer + TMR_W'(1);
            end
          end
          ST_FETCH: begin
            if (in_valid) begin
              timer <= '0;
              state <= ST_ACK_LO;
            end
          end
          ST_ACK_LO: begin
            if (!ack_s) begin
              req   <= 1'b1;
              timer <= '0;
              state <= ST_ACK_HI;
            end else if (to_hit) begin
              done  <= 1'b1;
              sent  <= idx;
              state <= ST_IDLE;
            end else begin
              timer <= timer + TMR_W'(1);
            end
          end
          ST_ACK_HI: begin
            if (ack_s) begin
              req   <= 1'b0;
              idx   <= idx_nxt;
              timer <= '0;
              if (idx_nxt == total)     state <= ST_LAST;
              else if (idx_nxt == pidx) state <= ST_PAUSE;
              else                      state <= ST_FETCH;
            end else if (to_hit) begin
              req   <= 1'b0;
              done  <= 1'b1;
              sent  <= idx;
              state <= ST_IDLE;
            end else begin
              timer <= timer + TMR_W'(1);
            end
          end
          ST_LAST: begin
            if (!ack_s || to_hit) begin
              done  <= 1'b1;
              sent  <= idx;
              state <= ST_IDLE;
            end else begin
              timer <= timer + TMR_W'(1);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  p_req_after_ack_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> !$past(ack_s));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_sent_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sent <= total));

  p_no_req_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req);

endmodule

// File: rtl/tgt_send_engine.sv
module tgt_send_engine #(
  parameter int CNT_W          = 16,
  parameter int PAUSE_CYCLES   = 20000,
  parameter int TIMEOUT_CYCLES = 600000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [CNT_W-1:0] pause_index,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] sent_count,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  input  logic             ack_in,
  input  logic             bus_rst_in,
  output logic             req_out,
  output logic [7:0]       data_out,
  output logic             parity_out
);

  logic [1:0] sync_q;
  logic       ack_s, bus_rst_s, load;

  tgt_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bus_rst_in, ack_in}),
    .q     (sync_q)
  );

  assign ack_s     = sync_q[0];
  assign bus_rst_s = sync_q[1];

  tgt_send_fsm #(
    .CNT_W          (CNT_W),
    .PAUSE_CYCLES   (PAUSE_CYCLES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .byte_count  (byte_count),
    .pause_index (pause_index),
    .in_valid    (in_valid),
    .ack_s       (ack_s),
    .bus_rst_s   (bus_rst_s),
    .in_ready    (in_ready),
    .load        (load),
    .req         (req_out),
    .busy        (busy),
    .done        (done),
    .sent        (sent_count)
  );

  tgt_byte_latch #(.DW(8)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .din   (in_data),
    .dout  (data_out),
    .par   (parity_out)
  );

  p_data_still_under_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_out && $past(req_out)) |-> $stable(data_out));

endmodule

// File: tb/tgt_send_engine_test.sv
`timescale 1ns/1ps
module tgt_send_engine_test;
  localparam int CW = 8;
  localparam int PC = 40;
  localparam int TC = 120;
  localparam int NV = 7;
  // {count, pause_index, seed, ack_delay}
  localparam logic [31:0] VEC [NV] = '{
    {8'd4, 8'd2, 8'h10, 8'd1},
    {8'd3, 8'd0, 8'hA5, 8'd0},
    {8'd5, 8'd5, 8'h3C, 8'd2},
    {8'd6, 8'd9, 8'hFF, 8'd1},
    {8'd0, 8'd0, 8'h00, 8'd0},
    {8'd1, 8'd0, 8'h7E, 8'd3},
    {8'd8, 8'd7, 8'h01, 8'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0, ack_in = 1'b0, bus_rst_in = 1'b0;
  logic [CW-1:0] byte_count = '0, pause_index = '0;
  logic [7:0] in_data = '0;
  logic busy, done, in_ready, req_out, parity_out;
  logic [CW-1:0] sent_count;
  logic [7:0] data_out;
  int n_checks = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tgt_send_engine #(.CNT_W(CW), .PAUSE_CYCLES(PC), .TIMEOUT_CYCLES(TC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .pause_index(pause_index), .busy(busy), .done(done), .sent_count(sent_count),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .ack_in(ack_in), .bus_rst_in(bus_rst_in), .req_out(req_out),
    .data_out(data_out), .parity_out(parity_out));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic send_stream(input logic [7:0] seed, input int n);
    for (int i = 0; i < n; i++) begin
      bit hs;
      in_valid = 1'b1;
      in_data  = seed + 8'(i);
      forever begin
        hs = in_ready;
        @(negedge clk);
        if (hs) break;
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic wait_req(output bit seen);
    int w = 0;
    while (!req_out && w < 4 * TC + 2 * PC) begin
      @(negedge clk);
      w++;
    end
    seen = req_out;
  endtask

  task automatic serve(input int n, input int pidx, input int cnt, input int dly,
                       input logic [7:0] seed, input int t_start);
    int last_fall = t_start;
    for (int b = 0; b < n; b++) begin
      bit seen;
      int gap, k;
      logic [7:0] exp_d;
      exp_d = seed + 8'(b);
      wait_req(seen);
      chk(seen, "R2 req never rose", 0, 1);
      if (!seen) return;
      gap = cyc - last_fall;
      if (b == pidx && pidx < cnt) chk(gap >= PC, "R5 pause gap", gap, PC);
      else chk(gap < PC, "R6 unpaused gap", gap, PC - 1);
      chk(data_out == exp_d, "R3 data under req", data_out, exp_d);
      chk(parity_out == ~(^exp_d), "R4 parity", parity_out, ~(^exp_d));
      repeat (dly) @(negedge clk);
      chk(data_out == exp_d, "R3 data held", data_out, exp_d);
      ack_in = 1'b1;
      k = 0;
      while (req_out && k < 10) begin
        @(negedge clk);
        k++;
      end
      chk(k == 3, "R2 req drop latency", k, 3);
      last_fall = cyc;
      repeat (dly) @(negedge clk);
      ack_in = 1'b0;
    end
  endtask

  task automatic wait_done(output bit seen);
    int w = 0;
    while (!done && w < 2 * TC + 40) begin
      @(negedge clk);
      w++;
    end
    seen = done;
  endtask

  task automatic kick(input int cnt, input int pidx, output int t0);
    @(negedge clk);
    byte_count  = CW'(cnt);
    pause_index = CW'(pidx);
    start = 1'b1;
    t0 = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    bit seen;
    int t0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!req_out && !busy && !done && !in_ready, "R1 controls in reset",
        {req_out, busy, done, in_ready}, 0);
    chk(data_out == 8'h00 && parity_out == 1'b1, "R1 bus in reset",
        {data_out, parity_out}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!req_out && !busy && !in_ready, "R1 after reset", {req_out, busy, in_ready}, 0);

    // Vector table: count, pause index, seed, ack delay
    for (int v = 0; v < NV; v++) begin
      int cnt, pidx, dly;
      logic [7:0] seed;
      cnt  = int'(VEC[v][31:24]);
      pidx = int'(VEC[v][23:16]);
      seed = VEC[v][15:8];
      dly  = int'(VEC[v][7:0]);
      kick(cnt, pidx, t0);
      chk(busy, "R7 busy after start", busy, 1);
      fork
        send_stream(seed, cnt);
        serve(cnt, pidx, cnt, dly, seed, t0);
      join
      wait_done(seen);
      chk(seen, (cnt == 0) ? "R11 done for zero count" : "R7 done", seen, 1);
      chk(sent_count == CW'(cnt), "R7 sent count", sent_count, cnt);
      chk(!req_out, "R7 req low at done", req_out, 0);
      @(negedge clk);
      chk(!done && !busy, "R7 single pulse", {done, busy}, 0);
    end

    // R10: stalled stream does not time out
    kick(1, 5, t0);
    repeat (2 * TC) @(negedge clk);
    chk(in_ready && busy && !req_out && !done, "R10 stall holds",
        {in_ready, busy, req_out, done}, 4'b1100);
    fork
      send_stream(8'h55, 1);
      serve(1, 5, 1, 1, 8'h55, cyc);
    join
    wait_done(seen);
    chk(seen && sent_count == 1, "R10 completes after stall", sent_count, 1);
    @(negedge clk);

    // R8: ACK never asserted for the second byte
    kick(3, 9, t0);
    fork
      send_stream(8'h20, 2);
      begin
        serve(1, 9, 3, 0, 8'h20, t0);
        wait_req(seen);
        chk(seen, "R8 second req", seen, 1);
        wait_done(seen);
      end
    join
    chk(seen, "R8 timeout done", seen, 1);
    chk(sent_count == 1, "R8 completed count", sent_count, 1);
    chk(!req_out, "R8 req released", req_out, 0);
    @(negedge clk);

    // R2/R8: ACK stuck high, REQ must never rise
    ack_in = 1'b1;
    kick(2, 9, t0);
    send_stream(8'h40, 1);
    repeat (TC / 2) @(negedge clk);
    chk(!req_out, "R2 no req while ack high", req_out, 0);
    wait_done(seen);
    chk(seen && sent_count == 0, "R8 stuck ack count", sent_count, 0);
    chk(!req_out, "R2 req stayed low", req_out, 0);
    ack_in = 1'b0;
    repeat (4) @(negedge clk);

    // R9: bus reset mid-transfer
    kick(4, 9, t0);
    fork
      send_stream(8'h90, 3);
      begin
        serve(2, 9, 4, 1, 8'h90, t0);
        wait_req(seen);
        bus_rst_in = 1'b1;
        wait_done(seen);
      end
    join
    chk(seen, "R9 done on bus reset", seen, 1);
    chk(sent_count == 2, "R9 completed count", sent_count, 2);
    chk(!req_out, "R9 req released", req_out, 0);
    bus_rst_in = 1'b0;
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule